// File: doc/BRIEF.md
# Reconfigurable Bit-Table Memory

This block turns two 16-entry, 1-bit lookup tables (called F and G here) into a small read/write memory. An organisation input arranges the pair in one of three ways. As a 16x2 memory, one bit comes from each table at a shared address. As a 32x1 memory, the top address bit picks the table. As a 16x1 memory, only table F is used.

A second input picks how writes behave. Edge mode stores data on the rising clock edge. Level mode is transparent: while write enable is high, the read port already shows the data being written. Dual-port mode forces the 16x1 organisation and keeps both tables as mirror copies. The second read address then reads the copy independently of the write/read port.

Reads are combinational lookups. Contents survive changes of either mode and are cleared only by the synchronous reset. A surrounding cell drives the ports directly every cycle; there is no handshake.

Top module: `lutram_dual`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every bit of both tables, so every read after reset returns 0 on `rdata` and `rdata_b` until a write occurs.
- R2: With `org_mode` 0 or 3 (16x2), `addr[3:0]` selects the entry. A write stores `wdata[0]` in F and `wdata[1]` in G. A read returns F on `rdata[0]` and G on `rdata[1]`.
- R3: With `org_mode` 1 (32x1), `addr[4]`=0 selects table F and `addr[4]`=1 selects table G at `addr[3:0]`. A write stores `wdata[0]`. The read bit appears on `rdata[0]`, and `rdata[1]` is 0.
- R4: With `org_mode` 2 (16x1 single-port), only table F is written (with `wdata[0]`) and read. `rdata[1]` is 0 and table G keeps its contents.
- R5: With `wr_style` 0 or 3 (edge), a write happens at the rising edge where `we` is 1. Before that edge, reads show the old contents.
- R6: With `wr_style` 1 (level), while `we` is 1 the read port shows the bits being written, in the same cycle (`wdata[1:0]` in 16x2, otherwise `{0, wdata[0]}`). The value is stored at each rising edge with `we` high.
- R7: With `wr_style` 2 (dual-port), the organisation is 16x1 whatever `org_mode` is. Each write stores `wdata[0]` into both F and G at `addr[3:0]`. `rdata[0]` is F at `addr[3:0]` and `rdata_b` is G at `raddr_b`. A port-B read of the written entry shows the new bit only after the write edge.
- R8: In any `wr_style` other than 2, `rdata_b` is 0.
- R9: Changing `org_mode` or `wr_style` does not alter stored contents. For example, bits written as 16x2 read back through the 32x1 view.
- R10: Reads are combinational: a change of `addr` or `raddr_b` changes the read outputs in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears contents |
| org_mode | input | 2 | Organisation: 0/3 16x2, 1 32x1, 2 16x1 |
| wr_style | input | 2 | Write style: 0/3 edge, 1 level, 2 dual-port edge |
| we | input | 1 | Write enable |
| addr | input | ADDR_W+1 (5) | Write and primary read address; top bit used in 32x1 |
| wdata | input | 2 | Write data |
| raddr_b | input | ADDR_W (4) | Independent read address for dual-port mode |
| rdata | output | 2 | Primary read data |
| rdata_b | output | 1 | Second-port read data |

## Verification
The assertions assume the inputs are known values at every rising edge. They also assume that a write followed by a read-back of the same entry keeps `addr` and `org_mode` unchanged across the edge; each property only checks the cases where this holds. The stimulus drives every input shortly after the falling edge, so it is stable at the active edge. The random part mixes all four codes of both mode inputs, so mode changes between a write and a later read are covered. The directed part exercises reads of the entry being written in the cycle before and after its edge.

// File: rtl/lutram_pkg.sv
// Package: shared mode types and decoders for the bit-table memory.
// Assumes: 2-bit mode codes; unused codes alias to a defined mode.
package lutram_pkg;

    typedef enum logic [1:0] {
        ORG_WIDE   = 2'd0,
        ORG_DEEP   = 2'd1,
        ORG_NARROW = 2'd2
    } org_e;

    typedef enum logic [1:0] {
        WS_EDGE  = 2'd0,
        WS_LEVEL = 2'd1,
        WS_DUAL  = 2'd2
    } wstyle_e;

    // Map the raw write-style code; code 3 behaves as edge.
    function automatic wstyle_e decode_style(input logic [1:0] code);
        case (code)
            2'd1:    return WS_LEVEL;
            2'd2:    return WS_DUAL;
            default: return WS_EDGE;
        endcase
    endfunction

    // Map the raw organisation code; dual-port style forces 16x1.
    function automatic org_e decode_org(input logic [1:0] code, input wstyle_e sty);
        if (sty == WS_DUAL) return ORG_NARROW;
        case (code)
            2'd1:    return ORG_DEEP;
            2'd2:    return ORG_NARROW;
            default: return ORG_WIDE;
        endcase
    endfunction

endpackage

// File: rtl/lutram_table.sv
// Module: one bit table of DEPTH entries with one write port and two
// combinational read ports.
// Assumes: wr_en is already qualified by mode; reset is synchronous low.
module lutram_table #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic              rd_a,
    output logic              rd_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] cells;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        // Store one bit: clear on reset, load when this entry is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[i] <= 1'b0;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                cells[i] <= wr_bit;
            end
        end
    end

    // Asynchronous lookups on both read ports.
    always_comb begin
        rd_a = cells[rd_addr_a];
        rd_b = cells[rd_addr_b];
    end

endmodule

// File: rtl/lutram_wctl.sv
// Module: decodes the mode inputs and steers write enables and data bits
// to the two tables.
// Assumes: pure combinational; the raw codes may hold any value.
module lutram_wctl
    import lutram_pkg::*;
(
    input  logic [1:0] org_mode,
    input  logic [1:0] wr_style,
    input  logic       we,
    input  logic       sel_hi,
    input  logic [1:0] wdata,
    output org_e       eff_org,
    output wstyle_e    eff_style,
    output logic       f_we,
    output logic       g_we,
    output logic       f_bit,
    output logic       g_bit
);
    // Resolve the effective organisation and write style.
    always_comb begin
        eff_style = decode_style(wr_style);
        eff_org   = decode_org(org_mode, eff_style);
    end

    // Route the enable and data to each table according to the organisation.
    always_comb begin
        f_we  = 1'b0;
        g_we  = 1'b0;
        f_bit = wdata[0];
        g_bit = wdata[0];
        case (eff_org)
            ORG_WIDE: begin
                f_we  = we;
                g_we  = we;
                g_bit = wdata[1];
            end
            ORG_DEEP: begin
                f_we = we && !sel_hi;
                g_we = we && sel_hi;
            end
            ORG_NARROW: begin
                f_we = we;
                g_we = we && (eff_style == WS_DUAL);
            end
            default: begin
                f_we = 1'b0;
                g_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lutram_rmux.sv
// Module: forms the read outputs from the table lookups, with write
// transparency in level style.
// Assumes: table outputs are combinational; pure combinational.
module lutram_rmux
    import lutram_pkg::*;
(
    input  org_e       eff_org,
    input  wstyle_e    eff_style,
    input  logic       we,
    input  logic       sel_hi,
    input  logic [1:0] wdata,
    input  logic       f_rd,
    input  logic       g_rd,
    input  logic       g_rd_b,
    output logic [1:0] rdata,
    output logic       rdata_b
);
    logic [1:0] stored;

    // Pick the stored bits for the active organisation.
    always_comb begin
        case (eff_org)
            ORG_WIDE:   stored = {g_rd, f_rd};
            ORG_DEEP:   stored = {1'b0, sel_hi ? g_rd : f_rd};
            ORG_NARROW: stored = {1'b0, f_rd};
            default:    stored = 2'b00;
        endcase
    end

    // Level style passes the write image through; dual style drives port B.
    always_comb begin
        if ((eff_style == WS_LEVEL) && we) begin
            rdata = (eff_org == ORG_WIDE) ? wdata : {1'b0, wdata[0]};
        end else begin
            rdata = stored;
        end
        rdata_b = (eff_style == WS_DUAL) ? g_rd_b : 1'b0;
    end

endmodule

// File: rtl/lutram_dual.sv
// Module: top of the reconfigurable bit-table memory. Two tables, a write
// steering decoder and a read multiplexer.
// Assumes: inputs are synchronous to clk; reset is synchronous active-low.
module lutram_dual
    import lutram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        org_mode,
    input  logic [1:0]        wr_style,
    input  logic              we,
    input  logic [ADDR_W:0]   addr,
    input  logic [1:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [1:0]        rdata,
    output logic              rdata_b
);
    localparam int IDX_W = ADDR_W;

    org_e             eff_org;
    wstyle_e          eff_style;
    logic             f_we, g_we, f_bit, g_bit;
    logic             f_rd, f_rd_b, g_rd, g_rd_b;
    logic             sel_hi;
    logic [IDX_W-1:0] idx;

    // Split the address into the table index and the table select bit.
    always_comb begin
        idx    = addr[IDX_W-1:0];
        sel_hi = addr[IDX_W];
    end

    lutram_wctl u_wctl (
        .org_mode  (org_mode),
        .wr_style  (wr_style),
        .we        (we),
        .sel_hi    (sel_hi),
        .wdata     (wdata),
        .eff_org   (eff_org),
        .eff_style (eff_style),
        .f_we      (f_we),
        .g_we      (g_we),
        .f_bit     (f_bit),
        .g_bit     (g_bit)
    );

    lutram_table #(.ADDR_W(ADDR_W)) u_tab_f (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (f_we),
        .wr_addr   (idx),
        .wr_bit    (f_bit),
        .rd_addr_a (idx),
        .rd_addr_b (raddr_b),
        .rd_a      (f_rd),
        .rd_b      (f_rd_b)
    );

    lutram_table #(.ADDR_W(ADDR_W)) u_tab_g (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (g_we),
        .wr_addr   (idx),
        .wr_bit    (g_bit),
        .rd_addr_a (idx),
        .rd_addr_b (raddr_b),
        .rd_a      (g_rd),
        .rd_b      (g_rd_b)
    );

    lutram_rmux u_rmux (
        .eff_org   (eff_org),
        .eff_style (eff_style),
        .we        (we),
        .sel_hi    (sel_hi),
        .wdata     (wdata),
        .f_rd      (f_rd),
        .g_rd      (g_rd),
        .g_rd_b    (g_rd_b),
        .rdata     (rdata),
        .rdata_b   (rdata_b)
    );

    // Port B of table F is kept for symmetry of the table module.
    logic unused_f_b;
    always_comb unused_f_b = f_rd_b;

endmodule

// File: rtl/lutram_dual_chk.sv
// Module: property checker for the bit-table memory, bound to the top.
// Assumes: inputs are known at every rising edge.
module lutram_dual_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        org_mode,
    input logic [1:0]        wr_style,
    input logic              we,
    input logic [ADDR_W:0]   addr,
    input logic [1:0]        wdata,
    input logic [ADDR_W-1:0] raddr_b,
    input logic [1:0]        rdata,
    input logic              rdata_b
);
    logic was_rst;

    // Remember that the previous edge was a reset edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: first cycle after reset reads zeros (unless level bypass is active)
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst && !(wr_style == 2'd1 && we)) |-> (rdata == 2'b00 && rdata_b == 1'b0));

    // R2: a 16x2 write reads back at the same address after the edge
    a_r2_wide_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ((org_mode == 2'd0 || org_mode == 2'd3) && wr_style != 2'd2 && we)
        |=> ((addr == $past(addr) && org_mode == $past(org_mode) && wr_style != 2'd2
              && !(wr_style == 2'd1 && we)) -> (rdata == $past(wdata))));

    // R3: the 32x1 view never drives the upper read bit
    a_r3_deep_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (org_mode == 2'd1 || org_mode == 2'd2 || wr_style == 2'd2) |-> (rdata[1] == 1'b0));

    // R6: level style is transparent in the 16x2 view
    a_r6_level_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_style == 2'd1 && we && (org_mode == 2'd0 || org_mode == 2'd3)) |-> (rdata == wdata));

    // R7: port B sees the mirrored write one edge later
    a_r7_dual_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_style == 2'd2 && we)
        |=> ((wr_style == 2'd2 && raddr_b == $past(addr[ADDR_W-1:0])) -> (rdata_b == $past(wdata[0]))));

    // R8: port B is silent outside dual-port style
    a_r8_portb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_style != 2'd2) |-> (rdata_b == 1'b0));

endmodule

bind lutram_dual lutram_dual_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .org_mode (org_mode),
    .wr_style (wr_style),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .raddr_b  (raddr_b),
    .rdata    (rdata),
    .rdata_b  (rdata_b)
);

// File: tb/lutram_dual_test.sv
module lutram_dual_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] org_mode = 2'd0;
    logic [1:0] wr_style = 2'd0;
    logic       we = 1'b0;
    logic [4:0] addr = 5'd0;
    logic [1:0] wdata = 2'd0;
    logic [3:0] raddr_b = 4'd0;
    logic [1:0] rdata;
    logic       rdata_b;

    int checks = 0;
    int failures = 0;
    bit mf [16];
    bit mg [16];

    always #2.5 clk = ~clk;

    lutram_dual uut (
        .clk(clk), .rst_n(rst_n), .org_mode(org_mode), .wr_style(wr_style),
        .we(we), .addr(addr), .wdata(wdata), .raddr_b(raddr_b),
        .rdata(rdata), .rdata_b(rdata_b)
    );

    function automatic int eff_org(input logic [1:0] o, input logic [1:0] s);
        if (s == 2'd2) return 2;
        if (o == 2'd3) return 0;
        return int'(o);
    endfunction

    function automatic logic [1:0] exp_a(input logic [4:0] a, input logic [1:0] o,
                                         input logic [1:0] s, input logic w, input logic [1:0] d);
        int eo = eff_org(o, s);
        if (s == 2'd1 && w) return (eo == 0) ? d : {1'b0, d[0]};
        case (eo)
            0:       return {mg[a[3:0]], mf[a[3:0]]};
            1:       return {1'b0, a[4] ? mg[a[3:0]] : mf[a[3:0]]};
            default: return {1'b0, mf[a[3:0]]};
        endcase
    endfunction

    function automatic logic exp_b(input logic [3:0] rb, input logic [1:0] s);
        return (s == 2'd2) ? mg[rb] : 1'b0;
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [1:0] o,
                               input logic [1:0] s, input logic [1:0] d);
        int eo = eff_org(o, s);
        case (eo)
            0: begin mf[a[3:0]] = d[0]; mg[a[3:0]] = d[1]; end
            1: if (a[4]) mg[a[3:0]] = d[0]; else mf[a[3:0]] = d[0];
            default: begin
                mf[a[3:0]] = d[0];
                if (s == 2'd2) mg[a[3:0]] = d[0];
            end
        endcase
    endtask

    task automatic check(input string tag, input logic [1:0] ea, input logic eb);
        checks++;
        if (rdata !== ea || rdata_b !== eb) begin
            failures++;
            $display("FAIL %s rdata=%b rdata_b=%b expected rdata=%b rdata_b=%b",
                     tag, rdata, rdata_b, ea, eb);
        end
    endtask

    // One cycle: drive after the falling edge, check before the rising edge.
    task automatic step(input string tag, input logic w, input logic [4:0] a,
                        input logic [1:0] d, input logic [1:0] o,
                        input logic [1:0] s, input logic [3:0] rb);
        @(negedge clk);
        we = w; addr = a; wdata = d; org_mode = o; wr_style = s; raddr_b = rb;
        #1;
        check(tag, exp_a(a, o, s, w, d), exp_b(rb, s));
        @(posedge clk);
        if (w) model_write(a, o, s, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0;
        repeat (2) @(posedge clk);
        foreach (mf[i]) begin mf[i] = 1'b0; mg[i] = 1'b0; end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic string tag_of(input logic [1:0] o, input logic [1:0] s);
        if (s == 2'd1) return "R6";
        if (s == 2'd2) return "R7";
        case (eff_org(o, s))
            0: return "R2";
            1: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R1: reset state
        step("R1", 1'b0, 5'd0,  2'd0, 2'd0, 2'd0, 4'd0);
        step("R1", 1'b0, 5'd15, 2'd0, 2'd0, 2'd2, 4'd15);
        // R5: edge write invisible before edge, R2: visible after
        step("R5", 1'b1, 5'd5, 2'b10, 2'd0, 2'd0, 4'd0);
        step("R2", 1'b0, 5'd5, 2'b00, 2'd0, 2'd3, 4'd0);
        // R3: deep view, upper half selects G
        step("R3", 1'b1, 5'b10011, 2'b01, 2'd1, 2'd0, 4'd0);
        step("R3", 1'b0, 5'b00011, 2'b00, 2'd1, 2'd0, 4'd0);
        step("R3", 1'b0, 5'b10011, 2'b00, 2'd1, 2'd0, 4'd0);
        // R9: mode change keeps contents
        step("R9", 1'b0, 5'd3, 2'b00, 2'd0, 2'd0, 4'd0);
        step("R9", 1'b0, 5'b10101, 2'b00, 2'd1, 2'd0, 4'd0);
        // R4: narrow write touches only F
        step("R4", 1'b1, 5'd5, 2'b01, 2'd2, 2'd0, 4'd0);
        step("R4", 1'b0, 5'd5, 2'b00, 2'd0, 2'd0, 4'd0);
        // R6: level transparency and storage
        step("R6", 1'b1, 5'd9, 2'b11, 2'd0, 2'd1, 4'd0);
        step("R6", 1'b0, 5'd9, 2'b00, 2'd0, 2'd1, 4'd0);
        // R7: dual mirror, port B updates after the edge
        step("R7", 1'b1, 5'd12, 2'b01, 2'd0, 2'd2, 4'd12);
        step("R7", 1'b0, 5'd0,  2'b00, 2'd0, 2'd2, 4'd12);
        step("R7", 1'b0, 5'd12, 2'b00, 2'd0, 2'd0, 4'd0);
        // R8: port B quiet in edge style even with a set G entry
        step("R8", 1'b0, 5'd12, 2'b00, 2'd1, 2'd3, 4'd12);
        // R10: combinational reads across addresses without writes
        for (int i = 0; i < 16; i++)
            step("R10", 1'b0, 5'(i), 2'b00, 2'd0, 2'd2, 4'(15 - i));
        // Random mix of all modes
        for (int n = 0; n < 600; n++) begin
            logic [1:0] o = 2'($urandom);
            logic [1:0] s = 2'($urandom);
            step(tag_of(o, s), 1'($urandom), 5'($urandom), 2'($urandom), o, s, 4'($urandom));
        end
        // R1: reset after traffic clears everything
        do_reset();
        for (int i = 0; i < 16; i++)
            step("R1", 1'b0, 5'(i), 2'b00, 2'd0, 2'd2, 4'(i));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule